// File: doc/BRIEF.md
# Multi-Cycle Exchange Sorter

This block holds a small bank of unsigned registers and sorts them into ascending order in place. An external writer fills the bank one register at a time by address while `start` is low. Raising `start` runs an exchange sort over every pair of registers. The sort uses one magnitude comparator, two working registers and two index counters, and a nine-state controller sequences all of it. When the pass finishes, `done` rises and stays high until `start` returns low. Any register can then be read back by address.

The datapath has a single write port into the bank, and a data mux feeds it. In the idle state the mux takes the external data input. During an exchange it takes one of the two working registers. A single select mux picks the row address from the outer index, the inner index or the external address. A decoder turns that row address into the per-row write enables.

The outer index `i` runs from 0 to K-2, and the inner index `j` runs from i+1 to K-1. Working register A holds R[i] and working register B holds R[j]. When B is strictly below A, three steps follow in order: R[j] takes A, R[i] takes B, and A reloads from R[i].

Top module: `xchg_sorter`

## Requirements
- R1: An active-low synchronous reset clears every bank register to zero and drives `done` low.
- R2: In the idle state with `start` low, a cycle with `wr_init` high writes `data_in` into the register at `addr` on that clock edge.
- R3: `wr_init` is ignored whenever `start` is high, including the cycle in which `start` rises and every cycle of a running sort.
- R4: When `done` is high, the bank holds the loaded values as a permutation in ascending unsigned order: R[0] <= R[1] <= ... <= R[K-1]. Values with the top bit set sort above all values with it clear.
- R5: A bank of equal values, or one that is already ascending, comes out of the sort unchanged.
- R6: Once `done` is high it stays high, with the bank unchanged, for as long as `start` stays high.
- R7: One clock edge after `start` is seen low while `done` is high, `done` falls and the block is back in the idle state, ready to accept writes.
- R8: `data_out` equals R[`addr`] whenever `rd_en` is high in the idle or done state. It is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Runs a sort when raised; holds the result while high |
| wr_init | input | 1 | Write strobe for external loading |
| addr | input | ADDR_W | Register address for both loading and read-back |
| data_in | input | DATA_W | Load data |
| rd_en | input | 1 | Read-back enable |
| data_out | output | DATA_W | Selected register when `rd_en` is high, zero otherwise |
| done | output | 1 | Sort complete |

## Verification
On every cycle the assertions check four things: the bank is in ascending order whenever `done` is high, `done` and the bank hold while `start` stays high, `done` drops after `start` falls, and read-back matches the addressed row. Only the bench's scenarios can show that the result is a permutation of what was loaded. The same holds for ignoring writes that arrive with `start` high, and for the unsigned ordering across the top bit. The bench shows these by comparing read-back against a copy it sorts itself, over reverse-ordered, equal, ascending and pseudo-random banks.

// File: rtl/xchg_sorter.sv
module xchg_sorter #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_init,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rd_en,
  output logic [DATA_W-1:0] data_out,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_J = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] LAST_I = ADDR_W'(NUM_REGS - 2);

  typedef enum logic [3:0] {
    ST_IDLE, ST_LDA, ST_INCJ, ST_LDB, ST_CMP,
    ST_WRJ, ST_WRI, ST_RELA, ST_DONE
  } state_t;

  state_t state;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank;
  logic [DATA_W-1:0] reg_a, reg_b, rd_bus, wdata;
  logic [ADDR_W-1:0] idx_i, idx_j, sel;
  logic [NUM_REGS-1:0] row_we;
  logic wr_en, j_end, i_end, b_lt_a, ext_sel;

  assign j_end   = (idx_j == LAST_J);
  assign i_end   = (idx_i == LAST_I);
  assign b_lt_a  = (reg_b < reg_a);
  assign ext_sel = (state == ST_IDLE) || (state == ST_DONE);

  always_comb begin
    if (ext_sel) sel = addr;
    else if (state == ST_LDB || state == ST_WRJ || state == ST_INCJ) sel = idx_j;
    else sel = idx_i;
  end

  assign rd_bus = bank[sel];
  assign wdata  = (state == ST_IDLE) ? data_in : ((state == ST_WRJ) ? reg_a : reg_b);
  assign wr_en  = (state == ST_IDLE && wr_init && !start) || state == ST_WRJ || state == ST_WRI;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_dec
      assign row_we[g] = wr_en && (sel == ADDR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) bank <= '0;
    else
      for (int r = 0; r < NUM_REGS; r++)
        if (row_we[r]) bank[r] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx_i <= '0;
      idx_j <= '0;
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          idx_i <= '0;
          if (start) state <= ST_LDA;
        end
        ST_LDA: begin
          reg_a <= rd_bus;
          idx_j <= idx_i;
          state <= ST_INCJ;
        end
        ST_INCJ: begin
          idx_j <= idx_j + 1'b1;
          state <= ST_LDB;
        end
        ST_LDB: begin
          reg_b <= rd_bus;
          state <= ST_CMP;
        end
        ST_CMP:  state <= b_lt_a ? ST_WRJ : ST_RELA;
        ST_WRJ:  state <= ST_WRI;
        ST_WRI:  state <= ST_RELA;
        ST_RELA: begin
          reg_a <= rd_bus;
          if (!j_end) state <= ST_INCJ;
          else if (i_end) state <= ST_DONE;
          else begin
            idx_i <= idx_i + 1'b1;
            state <= ST_LDA;
          end
        end
        ST_DONE: if (!start) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done     = (state == ST_DONE);
  assign data_out = (rd_en && ext_sel) ? rd_bus : '0;

endmodule

// File: rtl/xchg_sorter_chk.sv
module xchg_sorter_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            start,
  input logic                            rd_en,
  input logic [ADDR_W-1:0]               addr,
  input logic                            done,
  input logic [DATA_W-1:0]               data_out,
  input logic [NUM_REGS-1:0][DATA_W-1:0] bank
);

  genvar g;
  generate
    for (g = 0; g < NUM_REGS - 1; g++) begin : g_ord
      assert_sorted_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bank[g] <= bank[g+1]));
    end
  endgenerate

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  assert_bank_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> $stable(bank));

  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_en) |-> (data_out == bank[addr]));

endmodule

bind xchg_sorter xchg_sorter_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .addr(addr),
  .done(done), .data_out(data_out), .bank(bank)
);

// File: tb/xchg_sorter_bench.sv
module xchg_sorter_bench;
  localparam int K  = 4;
  localparam int W  = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr_init = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  data_in = '0;
  logic [W-1:0]  data_out;
  logic done;

  int n_vec = 0, n_bad = 0;
  int vals [K];
  int exp_v [K];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  xchg_sorter #(.NUM_REGS(K), .DATA_W(W)) u_xchg_sorter (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_init(wr_init), .addr(addr),
    .data_in(data_in), .rd_en(rd_en), .data_out(data_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load_bank();
    for (int r = 0; r < K; r++) begin
      @(negedge clk);
      wr_init = 1'b1; addr = AW'(r); data_in = W'(vals[r]);
    end
    @(negedge clk);
    wr_init = 1'b0;
  endtask

  task automatic ref_sort();
    for (int r = 0; r < K; r++) exp_v[r] = vals[r];
    for (int p = 0; p < K; p++)
      for (int q = 0; q < K - 1; q++)
        if (exp_v[q] > exp_v[q+1]) begin
          int t = exp_v[q]; exp_v[q] = exp_v[q+1]; exp_v[q+1] = t;
        end
  endtask

  task automatic run_and_wait(input bool_poke);
    int cnt = 0;
    @(negedge clk);
    start = 1'b1;
    if (bool_poke) begin
      wr_init = 1'b1; addr = '0; data_in = ~W'(exp_v[0]);
    end
    @(negedge clk);
    if (bool_poke) begin
      addr = AW'(K-1);
      repeat (5) @(negedge clk);
      wr_init = 1'b0;
    end
    while (!done && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done === 1'b1, "R4 sort reaches done", int'(done), 1);
  endtask

  task automatic read_check(input string req);
    for (int r = 0; r < K; r++) begin
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(r);
      #1 chk(int'(data_out) == exp_v[r], req, int'(data_out), exp_v[r]);
    end
    @(negedge clk);
    rd_en = 1'b0;
    #1 chk(data_out == '0, "R8 data_out zero with rd_en low", int'(data_out), 0);
  endtask

  task automatic release_start();
    chk(done === 1'b1, "R6 done held while start high", int'(done), 1);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R7 done falls after start low", int'(done), 0);
  endtask

  task automatic one_case(input string req, input bit poke);
    load_bank();
    ref_sort();
    run_and_wait(poke);
    read_check(req);
    release_start();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    for (int r = 0; r < K; r++) begin
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(r);
      #1 chk(data_out == '0, "R1 bank cleared", int'(data_out), 0);
    end
    @(negedge clk);
    rd_en = 1'b0;

    vals = '{9, 3, 12, 5};
    load_bank();
    for (int r = 0; r < K; r++) begin
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(r);
      #1 chk(int'(data_out) == vals[r], "R2 load then read in idle", int'(data_out), vals[r]);
    end
    @(negedge clk);
    rd_en = 1'b0;

    vals = '{15, 14, 13, 12}; one_case("R4 reverse high", 1'b0);
    vals = '{3, 2, 1, 0};     one_case("R4 reverse low", 1'b0);
    vals = '{8, 7, 15, 0};    one_case("R4 unsigned across top bit", 1'b0);
    vals = '{6, 1, 6, 1};     one_case("R4 duplicate pairs", 1'b0);
    for (int v = 0; v < 16; v++) begin
      vals = '{v, v, v, v};   one_case("R5 all equal", 1'b0);
    end
    vals = '{0, 4, 9, 15};    one_case("R5 already ascending", 1'b0);
    ref_sort();
    run_and_wait(1'b0);
    read_check("R5 resort of sorted bank");
    release_start();

    vals = '{11, 2, 7, 4};    one_case("R3 writes ignored during sort", 1'b1);

    for (int n = 0; n < 250; n++) begin
      for (int r = 0; r < K; r++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        vals[r] = int'(lfsr[3:0]);
      end
      one_case("R4 pseudo-random bank", 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule